// File: doc/BRIEF.md
# Serial Pattern Generator and Bit Error Checker

This block is a test-pattern engine for one serial port. Its transmit half sends one of three kinds of stream. The first two are maximal-length pseudorandom sequences of period 2^15-1 and 2^23-1. The third is a host-programmed word of 1 to 32 bits, repeated without end. On host command, the transmit half inverts single bits. It can also invert bits at a steady rate of one per 10^N bits.

The receive half locks onto the same kind of stream. It counts mismatched bits while locked and reports its lock state. The host takes a snapshot of the error count by pulsing a latch input. This copies the live count to a holding register and restarts the live count.

Each half has its own per-bit enable. Either half can therefore carry the pattern in every bit of a line, or only in payload bits, by gating the enable. Both halves use one clock and one active-low reset.

Top module: `bert_engine`

## Requirements
- R1: With `cfg_mode`=0, each transmitted bit b[n] equals b[n-14] XOR b[n-15] (polynomial x^15+x^14+1). The pseudorandom shift register in the generator and in the checker never holds all zeros.
- R2: With `cfg_mode`=1, each transmitted bit b[n] equals b[n-18] XOR b[n-23] (polynomial x^23+x^18+1).
- R3: With `cfg_mode`=2 or 3, the stream repeats `cfg_pat[L-1:0]` with L=`cfg_len_m1`+1 and `cfg_pat[0]` sent first in each period. Every L consecutive bits form a rotation of that word, and b[n]=b[n-L].
- R4: The generator advances only on cycles with `tx_en`=1, and the checker only on cycles with `rx_en`=1. `tx_valid` is `tx_en` delayed one cycle, and `tx_bit` holds its value while `tx_en` is low.
- R5: Each one-cycle pulse on `inj_one` inverts exactly one bit: the next enabled transmit bit.
- R6: A value N of 1 to 7 on `cfg_rate` inverts one enabled transmit bit in every 10^N. A value of 0 disables rate insertion.
- R7: In the pseudorandom modes, the checker seeds itself from the received bits and declares lock after 32 consecutive bits that match its prediction. An all-zero input never brings lock.
- R8: In the repeated-word modes, the checker searches the last L received bits against every rotation of the word. After it finds a rotation, it declares lock after 32 further matching bits. A mismatch during those 32 bits returns it to the search.
- R9: Mismatches are counted only while `rx_sync`=1. Each counted mismatch raises `rx_bit_err` for one cycle, one cycle after the bit.
- R10: While locked, the checker counts errors in consecutive 64-bit windows that begin at lock. The 6th error inside one window drops `rx_sync` and restarts the search.
- R11: The live error counter (24 bits by default) stops at its all-ones value.
- R12: A pulse on `cnt_latch` copies the live count to `err_hold` and restarts the live count at 0. If an error is counted in that same cycle, the live count restarts at 1 instead.
- R13: After reset, `tx_bit`, `tx_valid`, `rx_sync`, `rx_bit_err` and `err_hold` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | 0: 2^15-1 sequence, 1: 2^23-1 sequence, 2 or 3: repeated word |
| cfg_pat | input | 32 | Repeated word, bit 0 sent first |
| cfg_len_m1 | input | 5 | Repeated word length minus one |
| cfg_rate | input | 3 | Rate insertion exponent N, where 0 means off |
| inj_one | input | 1 | Single-bit error request |
| cnt_latch | input | 1 | Copy the error count to the holding register and clear the count |
| tx_en | input | 1 | Transmit bit enable |
| tx_bit | output | 1 | Transmitted pattern bit |
| tx_valid | output | 1 | `tx_bit` carries a new bit |
| rx_en | input | 1 | Receive bit enable |
| rx_bit | input | 1 | Received bit |
| rx_sync | output | 1 | Checker is locked |
| rx_bit_err | output | 1 | One-cycle pulse for each counted mismatch |
| err_hold | output | 24 | Latched error count |

## Verification
The embedded properties check the following on every cycle:
- the generator's shift register is never zero;
- `tx_bit` is frozen while transmit is idle;
- the live count does not move while the checker is unlocked;
- error pulses occur only in lock;
- the count saturates;
- a latch copies the previous count.

The directed scenarios are needed for the rest:
- that the sequences obey their recurrences;
- that repeated words come out in the stated order;
- the lock and loss thresholds;
- the exact number of inverted bits at a given rate;
- alignment to an arbitrary rotation of the word.

A second instance with a 4-bit counter shows saturation within a short run.

// File: rtl/bert_pkg.sv
package bert_pkg;

    typedef enum logic [1:0] {
        SRC_PN15  = 2'd0,
        SRC_PN23  = 2'd1,
        SRC_WORD  = 2'd2,
        SRC_WORDB = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        CHK_HUNT  = 2'd0,
        CHK_ALIGN = 2'd1,
        CHK_LOCK  = 2'd2
    } chk_st_e;

    localparam int PN_LEN = 23;

    // next pseudorandom bit from the current register contents
    function automatic logic pn_tap(input logic [PN_LEN-1:0] s, input logic long_poly);
        return long_poly ? (s[22] ^ s[17]) : (s[14] ^ s[13]);
    endfunction

    // active part of the register is all zeros
    function automatic logic pn_dead(input logic [PN_LEN-1:0] s, input logic long_poly);
        return long_poly ? (s == '0) : (s[14:0] == '0);
    endfunction

endpackage

// File: rtl/bert_inject.sv
module bert_inject #(
    parameter int RATE_W = 3,
    parameter int DIV_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [RATE_W-1:0] rate,
    input  logic              one_shot,
    output logic              flip
);
    typedef struct packed {
        logic             pend;
        logic [DIV_W-1:0] cnt;
    } inj_t;

    inj_t st_d, st_q;
    logic rate_hit;
    logic [DIV_W-1:0] lim;

    // 10^rate - 1
    function automatic logic [DIV_W-1:0] lim_of(input logic [RATE_W-1:0] n);
        logic [DIV_W-1:0] v;
        v = DIV_W'(1);
        for (int i = 1; i < (1 << RATE_W); i++) begin
            if (i <= int'(n)) v = DIV_W'(v * DIV_W'(10));
        end
        return v - DIV_W'(1);
    endfunction

    always_comb begin
        st_d     = st_q;
        rate_hit = 1'b0;
        lim      = lim_of(rate);
        if (rate == '0) begin
            st_d.cnt = '0;
        end else if (bit_en) begin
            if (st_q.cnt >= lim) begin
                rate_hit = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
        flip      = bit_en & (st_q.pend | one_shot | rate_hit);
        st_d.pend = (st_q.pend | one_shot) & ~bit_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RATE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rate != '0 && $stable(rate)) |-> (st_q.cnt <= lim)) else $error("rate counter out of range"); // R6

endmodule

// File: rtl/bert_gen.sv
module bert_gen
    import bert_pkg::*;
#(
    parameter int PAT_W = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src,
    input  logic [PAT_W-1:0] pat,
    input  logic [IDX_W-1:0] len_m1,
    input  logic             bit_en,
    input  logic             flip,
    output logic             tx_bit,
    output logic             tx_valid
);
    typedef struct packed {
        logic [PN_LEN-1:0] pn;
        logic [IDX_W-1:0]  idx;
        logic              dat;
        logic              vld;
    } gen_t;

    gen_t g_d, g_q;
    logic long_poly, word;
    logic [PN_LEN-1:0] pn_cur;
    logic [IDX_W-1:0]  idx_cur;
    logic fb, raw;

    always_comb begin
        g_d       = g_q;
        long_poly = (src == SRC_PN23);
        word      = src[1];
        pn_cur    = pn_dead(g_q.pn, long_poly) ? '1 : g_q.pn;
        idx_cur   = (g_q.idx > len_m1) ? '0 : g_q.idx;
        fb        = pn_tap(pn_cur, long_poly);
        raw       = word ? pat[idx_cur] : fb;
        g_d.vld   = bit_en;
        if (bit_en) begin
            g_d.dat = raw ^ flip;
            if (word) g_d.idx = (idx_cur == len_m1) ? '0 : idx_cur + IDX_W'(1);
            else      g_d.pn  = {pn_cur[PN_LEN-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q     <= '0;
            g_q.pn  <= '1;
        end else begin
            g_q <= g_d;
        end
    end

    assign tx_bit   = g_q.dat;
    assign tx_valid = g_q.vld;

    AST_PN_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.pn != '0) else $error("generator register zero"); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit)) else $error("tx_bit moved while idle"); // R4
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> tx_valid) else $error("tx_valid missing"); // R4

endmodule

// File: rtl/bert_chk.sv
module bert_chk
    import bert_pkg::*;
#(
    parameter int PAT_W    = 32,
    parameter int IDX_W    = 5,
    parameter int CNT_W    = 24,
    parameter int SYNC_RUN = 32,
    parameter int WIN_LEN  = 64,
    parameter int LOSS_ERR = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src,
    input  logic [PAT_W-1:0] pat,
    input  logic [IDX_W-1:0] len_m1,
    input  logic             rx_en,
    input  logic             rx_bit,
    input  logic             latch,
    output logic             rx_sync,
    output logic             rx_bit_err,
    output logic [CNT_W-1:0] err_hold
);
    localparam int RUN_W  = $clog2(SYNC_RUN + 1);
    localparam int WIN_W  = $clog2(WIN_LEN);
    localparam int LERR_W = $clog2(LOSS_ERR + 1);
    localparam int SEEN_W = $clog2(PAT_W + 1);

    typedef struct packed {
        chk_st_e           st;
        logic [PN_LEN-1:0] pn;
        logic [PAT_W-1:0]  hist;
        logic [SEEN_W-1:0] seen;
        logic [IDX_W-1:0]  idx;
        logic [RUN_W-1:0]  good;
        logic [WIN_W-1:0]  win;
        logic [LERR_W-1:0] werr;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  hold;
        logic              berr;
    } chk_t;

    chk_t c_d, c_q;
    logic long_poly, word, expb, mism, cnt_inc;
    logic [PN_LEN-1:0] pn_cur;
    logic [IDX_W-1:0]  idx_cur, idx_nxt;
    logic [PAT_W-1:0]  hist_n;
    logic [SEEN_W-1:0] seen_n;
    logic [IDX_W:0]    rot;
    logic [LERR_W-1:0] werr_n;

    // {found, index of the next expected bit}; h[0] is the newest bit
    function automatic logic [IDX_W:0] rot_search(input logic [PAT_W-1:0] h,
                                                  input logic [PAT_W-1:0] w,
                                                  input logic [IDX_W-1:0] lm1);
        int   len, k;
        logic hit, ok;
        logic [IDX_W-1:0] nxt;
        len = int'(lm1) + 1;
        hit = 1'b0;
        nxt = '0;
        for (int r = 0; r < PAT_W; r++) begin
            if (!hit && r < len) begin
                ok = 1'b1;
                for (int j = 0; j < PAT_W; j++) begin
                    if (j < len) begin
                        k = r - j;
                        if (k < 0) k = k + len;
                        if (h[j] != w[k]) ok = 1'b0;
                    end
                end
                if (ok) begin
                    hit = 1'b1;
                    nxt = (r == len - 1) ? '0 : IDX_W'(r + 1);
                end
            end
        end
        return {hit, nxt};
    endfunction

    always_comb begin
        c_d       = c_q;
        c_d.berr  = 1'b0;
        long_poly = (src == SRC_PN23);
        word      = src[1];
        pn_cur    = pn_dead(c_q.pn, long_poly) ? '1 : c_q.pn;
        idx_cur   = (c_q.idx > len_m1) ? '0 : c_q.idx;
        idx_nxt   = (idx_cur == len_m1) ? '0 : idx_cur + IDX_W'(1);
        expb      = word ? pat[idx_cur] : pn_tap(pn_cur, long_poly);
        mism      = rx_bit ^ expb;
        hist_n    = {c_q.hist[PAT_W-2:0], rx_bit};
        seen_n    = (int'(c_q.seen) >= PAT_W) ? c_q.seen : c_q.seen + SEEN_W'(1);
        rot       = rot_search(hist_n, pat, len_m1);
        werr_n    = c_q.werr + LERR_W'(mism);
        cnt_inc   = rx_en && (c_q.st == CHK_LOCK) && mism;

        if (rx_en) begin
            c_d.hist = hist_n;
            c_d.seen = seen_n;
            if (word) c_d.idx = idx_nxt;
            else      c_d.pn  = {pn_cur[PN_LEN-2:0], (c_q.st == CHK_LOCK) ? expb : rx_bit};

            if (c_q.st == CHK_LOCK) begin
                c_d.berr = mism;
                if (mism && c_q.cnt != '1) c_d.cnt = c_q.cnt + CNT_W'(1);
                if (int'(werr_n) >= LOSS_ERR) begin
                    c_d.st   = CHK_HUNT;
                    c_d.good = '0;
                    c_d.win  = '0;
                    c_d.werr = '0;
                end else if (int'(c_q.win) == WIN_LEN - 1) begin
                    c_d.win  = '0;
                    c_d.werr = '0;
                end else begin
                    c_d.win  = c_q.win + WIN_W'(1);
                    c_d.werr = werr_n;
                end
            end else if (word && c_q.st == CHK_HUNT) begin
                if (rot[IDX_W] && int'(seen_n) > int'(len_m1)) begin
                    c_d.idx  = rot[IDX_W-1:0];
                    c_d.st   = CHK_ALIGN;
                    c_d.good = '0;
                end
            end else begin
                if (mism) begin
                    c_d.good = '0;
                    if (word) c_d.st = CHK_HUNT;
                end else if (int'(c_q.good) == SYNC_RUN - 1) begin
                    c_d.st   = CHK_LOCK;
                    c_d.good = '0;
                    c_d.win  = '0;
                    c_d.werr = '0;
                end else begin
                    c_d.good = c_q.good + RUN_W'(1);
                end
            end
        end

        if (latch) begin
            c_d.hold = c_q.cnt;
            c_d.cnt  = cnt_inc ? CNT_W'(1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= CHK_HUNT;
            c_q.pn <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    assign rx_sync    = (c_q.st == CHK_LOCK);
    assign rx_bit_err = c_q.berr;
    assign err_hold   = c_q.hold;

    AST_NO_COUNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st != CHK_LOCK && !latch) |=> $stable(c_q.cnt)) else $error("count moved out of lock"); // R9
    AST_ERR_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.berr |-> $past(c_q.st == CHK_LOCK)) else $error("error pulse out of lock"); // R9
    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.cnt == '1 && !latch) |=> (c_q.cnt == '1)) else $error("counter wrapped"); // R11
    AST_LATCH_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (c_q.hold == $past(c_q.cnt) && c_q.cnt <= CNT_W'(1))) else $error("latch failed"); // R12

endmodule

// File: rtl/bert_engine.sv
module bert_engine #(
    parameter int PAT_W    = 32,
    parameter int CNT_W    = 24,
    parameter int RATE_W   = 3,
    parameter int DIV_W    = 24,
    parameter int SYNC_RUN = 32,
    parameter int WIN_LEN  = 64,
    parameter int LOSS_ERR = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 cfg_mode,
    input  logic [PAT_W-1:0]           cfg_pat,
    input  logic [$clog2(PAT_W)-1:0]   cfg_len_m1,
    input  logic [RATE_W-1:0]          cfg_rate,
    input  logic                       inj_one,
    input  logic                       cnt_latch,
    input  logic                       tx_en,
    output logic                       tx_bit,
    output logic                       tx_valid,
    input  logic                       rx_en,
    input  logic                       rx_bit,
    output logic                       rx_sync,
    output logic                       rx_bit_err,
    output logic [CNT_W-1:0]           err_hold
);
    localparam int IDX_W = $clog2(PAT_W);

    logic flip;

    bert_inject #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_inject (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (tx_en),
        .rate     (cfg_rate),
        .one_shot (inj_one),
        .flip     (flip)
    );

    bert_gen #(.PAT_W(PAT_W), .IDX_W(IDX_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (cfg_mode),
        .pat      (cfg_pat),
        .len_m1   (cfg_len_m1),
        .bit_en   (tx_en),
        .flip     (flip),
        .tx_bit   (tx_bit),
        .tx_valid (tx_valid)
    );

    bert_chk #(
        .PAT_W(PAT_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
        .SYNC_RUN(SYNC_RUN), .WIN_LEN(WIN_LEN), .LOSS_ERR(LOSS_ERR)
    ) u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (cfg_mode),
        .pat        (cfg_pat),
        .len_m1     (cfg_len_m1),
        .rx_en      (rx_en),
        .rx_bit     (rx_bit),
        .latch      (cnt_latch),
        .rx_sync    (rx_sync),
        .rx_bit_err (rx_bit_err),
        .err_hold   (err_hold)
    );

endmodule

// File: tb/bert_engine_tb.sv
module bert_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [31:0] cfg_pat = 32'h0;
    logic [4:0]  cfg_len_m1 = 5'd0;
    logic [2:0]  cfg_rate = 3'd0;
    logic        inj_one = 1'b0;
    logic        cnt_latch = 1'b0;
    logic        tx_en = 1'b0;
    logic        loop = 1'b1;
    logic        drv_en = 1'b0;
    logic        drv_bit = 1'b0;
    logic        tx_bit, tx_valid, rx_sync, rx_bit_err;
    logic        rx_en, rx_bit;
    logic [23:0] err_hold;
    logic        s_tx_bit, s_tx_valid, s_sync, s_berr;
    logic [3:0]  s_hold;

    int n_chk = 0;
    int n_fail = 0;
    logic cap [0:1023];
    int   cap_n = 0;
    logic cap_on = 1'b0;

    always #4 clk = ~clk;

    assign rx_en  = loop ? tx_valid : drv_en;
    assign rx_bit = loop ? tx_bit   : drv_bit;

    bert_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pat(cfg_pat),
        .cfg_len_m1(cfg_len_m1), .cfg_rate(cfg_rate), .inj_one(inj_one),
        .cnt_latch(cnt_latch), .tx_en(tx_en), .tx_bit(tx_bit), .tx_valid(tx_valid),
        .rx_en(rx_en), .rx_bit(rx_bit), .rx_sync(rx_sync), .rx_bit_err(rx_bit_err),
        .err_hold(err_hold)
    );

    bert_engine #(.CNT_W(4)) u_sat (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pat(cfg_pat),
        .cfg_len_m1(cfg_len_m1), .cfg_rate(cfg_rate), .inj_one(inj_one),
        .cnt_latch(cnt_latch), .tx_en(tx_en), .tx_bit(s_tx_bit), .tx_valid(s_tx_valid),
        .rx_en(rx_en), .rx_bit(rx_bit), .rx_sync(s_sync), .rx_bit_err(s_berr),
        .err_hold(s_hold)
    );

    always @(negedge clk) begin
        if (cap_on && tx_valid && cap_n < 1024) begin
            cap[cap_n] = tx_bit;
            cap_n++;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_latch();
        cnt_latch = 1'b1;
        @(negedge clk);
        cnt_latch = 1'b0;
    endtask

    task automatic pulse_inj();
        inj_one = 1'b1;
        @(negedge clk);
        inj_one = 1'b0;
    endtask

    task automatic capture(input int n);
        cap_n  = 0;
        cap_on = 1'b1;
        wait (cap_n >= n);
        @(negedge clk);
        cap_on = 1'b0;
    endtask

    // count of bits that break the recurrence b[n] = b[n-a] ^ b[n-b]
    function automatic int pn_bad(input int a, input int b);
        int bad = 0;
        for (int n = b; n < cap_n; n++)
            if (cap[n] != (cap[n-a] ^ cap[n-b])) bad++;
        return bad;
    endfunction

    function automatic int word_bad(input logic [31:0] w, input int len);
        int bad = 0;
        logic rot_ok;
        for (int n = len; n < cap_n; n++)
            if (cap[n] != cap[n-len]) bad++;
        rot_ok = 1'b0;
        for (int r = 0; r < len; r++) begin
            logic m = 1'b1;
            for (int k = 0; k < len; k++)
                if (cap[k] != w[(r + k) % len]) m = 1'b0;
            if (m) rot_ok = 1'b1;
        end
        if (!rot_ok) bad++;
        return bad;
    endfunction

    task automatic t_reset();
        check(rx_sync == 0,    "R13 rx_sync",  int'(rx_sync), 0);
        check(tx_valid == 0,   "R13 tx_valid", int'(tx_valid), 0);
        check(tx_bit == 0,     "R13 tx_bit",   int'(tx_bit), 0);
        check(err_hold == 0,   "R13 err_hold", int'(err_hold), 0);
        check(rx_bit_err == 0, "R13 rx_bit_err", int'(rx_bit_err), 0);
    endtask

    task automatic t_prbs(input logic [1:0] m, input string req, input int a, input int b);
        int bad;
        cfg_mode = m;
        loop = 1'b1;
        tx_en = 1'b1;
        cycles(400);
        capture(300);
        bad = pn_bad(a, b);
        check(bad == 0, req, bad, 0);
        check(rx_sync == 1, "R7 lock on clean sequence", int'(rx_sync), 1);
        do_latch();
        cycles(200);
        do_latch();
        check(err_hold == 0, "R9 clean stream has no errors", int'(err_hold), 0);
    endtask

    task automatic t_gapped();
        int bad;
        cfg_mode = 2'd1;
        loop = 1'b1;
        do_latch();
        cap_n = 0;
        cap_on = 1'b1;
        for (int i = 0; i < 500; i++) begin
            tx_en = (i % 2 == 0) || (i % 7 == 3);
            @(negedge clk);
        end
        cap_on = 1'b0;
        tx_en = 1'b1;
        cycles(4);
        bad = pn_bad(18, 23);
        check(bad == 0 && cap_n > 200, "R4 gated sequence continuous", bad, 0);
        check(rx_sync == 1, "R4 checker held lock under gating", int'(rx_sync), 1);
        do_latch();
        check(err_hold == 0, "R4 no errors under gating", int'(err_hold), 0);
    endtask

    task automatic t_word(input logic [31:0] w, input int len);
        int bad;
        cfg_mode = 2'd2;
        cfg_pat = w;
        cfg_len_m1 = 5'(len - 1);
        loop = 1'b1;
        tx_en = 1'b1;
        cycles(450);
        capture(3 * len + 10);
        bad = word_bad(w, len);
        check(bad == 0, "R3 repeated word order", bad, 0);
        check(rx_sync == 1, "R8 word lock", int'(rx_sync), 1);
        do_latch();
        cycles(100);
        do_latch();
        check(err_hold == 0, "R8 word no errors", int'(err_hold), 0);
    endtask

    task automatic t_offset();
        logic [31:0] w = 32'h5B;
        cfg_mode = 2'd3;
        cfg_pat = w;
        cfg_len_m1 = 5'd6;
        loop = 1'b0;
        drv_en = 1'b1;
        for (int k = 0; k < 300; k++) begin
            drv_bit = w[(k + 3) % 7];
            if (k == 200) cnt_latch = 1'b1;
            if (k == 201) cnt_latch = 1'b0;
            @(negedge clk);
        end
        check(rx_sync == 1, "R8 lock on shifted rotation", int'(rx_sync), 1);
        do_latch();
        check(err_hold == 0, "R8 shifted rotation error free", int'(err_hold), 0);
    endtask

    task automatic t_zero();
        cfg_mode = 2'd0;
        loop = 1'b0;
        drv_en = 1'b1;
        drv_bit = 1'b0;
        cycles(300);
        check(rx_sync == 0, "R7 zeros never lock", int'(rx_sync), 0);
        do_latch();
        cycles(200);
        check(rx_sync == 0, "R7 zeros never lock late", int'(rx_sync), 0);
        do_latch();
        check(err_hold == 0, "R9 no counting while hunting", int'(err_hold), 0);
    endtask

    task automatic t_rate();
        cfg_mode = 2'd0;
        loop = 1'b1;
        tx_en = 1'b1;
        cycles(300);
        check(rx_sync == 1, "R6 lock before rate test", int'(rx_sync), 1);
        cfg_rate = 3'd2;
        cycles(50);
        do_latch();
        cycles(999);
        do_latch();
        check(err_hold == 10, "R6 one error per 100 bits", int'(err_hold), 10);
        cfg_rate = 3'd0;
        cycles(200);
    endtask

    task automatic t_inject();
        do_latch();
        for (int i = 0; i < 20; i++) begin
            pulse_inj();
            cycles(100);
        end
        check(rx_sync == 1, "R5 single errors keep lock", int'(rx_sync), 1);
        do_latch();
        check(err_hold == 20, "R5 one bit per request", int'(err_hold), 20);
        check(s_hold == 4'd15, "R11 counter saturates", int'(s_hold), 15);
    endtask

    task automatic t_loss();
        cfg_rate = 3'd1;
        cycles(300);
        check(rx_sync == 0, "R10 lock lost at high error rate", int'(rx_sync), 0);
        cfg_rate = 3'd0;
        cycles(300);
        check(rx_sync == 1, "R10 relock after errors stop", int'(rx_sync), 1);
    endtask

    task automatic t_latch();
        do_latch();
        for (int i = 0; i < 3; i++) begin
            pulse_inj();
            cycles(100);
        end
        do_latch();
        check(err_hold == 3, "R12 latch copies count", int'(err_hold), 3);
        cycles(5);
        do_latch();
        check(err_hold == 0, "R12 latch cleared count", int'(err_hold), 0);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_prbs(2'd0, "R1 15-stage recurrence", 14, 15);
        t_prbs(2'd1, "R2 23-stage recurrence", 18, 23);
        t_gapped();
        t_word(32'h13, 5);
        t_word(32'h1, 1);
        t_word(32'hA5C3_0F96, 32);
        t_offset();
        t_zero();
        t_rate();
        t_inject();
        t_loss();
        t_latch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule